// File: doc/BRIEF.md
# Memory Region Fill Sequencer

This block carries out a block-initialize operation: it writes one 16-bit value into a run of consecutive 16-bit memory words. A start pulse comes with a 16-bit instruction word. The word holds an opcode, two 3-bit register selectors and an unsigned 6-bit word count. The block decodes the selectors onto two read-select outputs, and an external register file returns the base byte address and the fill value on two data inputs. The block latches those values on the start edge.

After that, the block steps a simple word-write memory interface. It presents an address, write data and a write enable, and holds them until the memory raises ready. It then advances the address by two bytes and decrements an internal count of remaining writes. When the last write has been accepted, a one-cycle done pulse follows. A count of zero writes nothing and still produces done. Instruction fetch, branching and condition codes stay outside the block.

Top module: `fill_seq`

## Requirements
- R1: While reset is asserted and after it is released with no accepted start, `mem_we` and `done` are 0.
- R2: A start is accepted only when `instr[15:12]` equals 4'b1010; with any other opcode the block makes no write and gives no done pulse.
- R3: `val_sel` always equals `instr[11:9]`, `base_sel` always equals `instr[8:6]`, and the word count is `instr[5:0]`.
- R4: An accepted start with count N (unsigned, 0 to 63) makes exactly N accepted writes. Write i goes to byte address base + 2*i, and every write carries the fill value latched at the start edge.
- R5: Bit 0 of `mem_addr` is 0 on every write, so an odd base address is rounded down to the even address below it.
- R6: While `mem_we` is high and `mem_ready` is low, `mem_addr`, `mem_wdata` and `mem_we` keep their values into the next cycle; the address advances only after a cycle with `mem_ready` high.
- R7: An accepted start with count 0 drives `done` high in the very next cycle, and `mem_we` stays low throughout.
- R8: `done` is high for exactly one cycle per accepted operation, in the cycle right after the last write is accepted, and never together with `mem_we`.
- R9: A start pulse arriving while an operation is in progress, including its done cycle, is ignored: it causes no extra write and no extra done.
- R10: The address advances modulo 2^16, so a run that passes 0xFFFE continues at 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request, sampled with `instr` |
| instr | input | 16 | Instruction word: opcode, value selector, base selector, count |
| val_sel | output | 3 | Register-file read select for the fill value |
| base_sel | output | 3 | Register-file read select for the base address |
| val_data | input | 16 | Fill value returned by the register file |
| base_data | input | 16 | Base byte address returned by the register file |
| mem_addr | output | 16 | Byte address of the current write |
| mem_wdata | output | 16 | Data of the current write |
| mem_we | output | 1 | Write request, held until accepted |
| mem_ready | input | 1 | Memory accepts the write in a cycle where this and `mem_we` are both high |
| done | output | 1 | One-cycle pulse when the operation has finished |

## Verification
The assertions assume that `mem_ready` is a clean 0 or 1 every cycle. They also assume that the register-file data inputs are valid in the cycle that `start` is high. The checker keeps its own view of the busy window, starting at an accepted start and ending at done, and checks that no write or done appears outside it. The bench's register-file model answers the select outputs combinationally in the same cycle. Its memory model toggles ready at random from a fixed seed so that the hold and advance rules are exercised under stalls. Repeated starts are issued only while an operation of at least four words is still writing, so each one falls inside the busy window.

// File: rtl/fill_pkg.sv
// Package fill_pkg
// Shared sequencer state type for the region fill sequencer.
// Assumes nothing beyond being compiled before its users.
package fill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_FINISH = 2'd2
    } fill_state_e;

endpackage

// File: rtl/fill_decode.sv
// Module fill_decode
// Splits the instruction word into the opcode match, two register selectors
// and the word count. Pure combinational logic.
// Assumes the field order opcode | value sel | base sel | count from MSB to LSB.
module fill_decode #(
    parameter int CNT_W  = 6,
    parameter int SEL_W  = 3,
    parameter int OPC_W  = 4,
    parameter logic [OPC_W-1:0] OPCODE = 4'b1010,
    localparam int INSTR_W = OPC_W + 2*SEL_W + CNT_W
) (
    input  logic [INSTR_W-1:0] instr,
    output logic [SEL_W-1:0]   val_sel,
    output logic [SEL_W-1:0]   base_sel,
    output logic [CNT_W-1:0]   count,
    output logic               opc_match,
    output logic               cnt_zero
);
    localparam int BASE_LSB = CNT_W;
    localparam int VAL_LSB  = CNT_W + SEL_W;
    localparam int OPC_LSB  = CNT_W + 2*SEL_W;

    // Field extraction and opcode comparison.
    always_comb begin
        count     = instr[CNT_W-1:0];
        base_sel  = instr[BASE_LSB +: SEL_W];
        val_sel   = instr[VAL_LSB +: SEL_W];
        opc_match = (instr[OPC_LSB +: OPC_W] == OPCODE);
        cnt_zero  = (instr[CNT_W-1:0] == '0);
    end
endmodule

// File: rtl/fill_counter.sv
// Module fill_counter
// Down-counter holding the number of writes still to perform.
// Assumes load and dec are never high in the same cycle.
module fill_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] remain_q;

    // Remaining-write register: load on start, decrement per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec && remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Flags the write that will empty the counter.
    always_comb begin
        last = (remain_q == CNT_W'(1));
    end
endmodule

// File: rtl/fill_addr_gen.sv
// Module fill_addr_gen
// Holds the current byte address and the fill value. Steps the address by
// one word's worth of bytes per accepted write and wraps at the address width.
// Assumes the word width is a whole number of bytes; low address bits that
// select a byte within a word are forced to zero.
module fill_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] value,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam int BYTES_PER_WORD = DATA_W / 8;
    localparam int ALIGN_BITS     = $clog2(BYTES_PER_WORD);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base_al;
    logic [DATA_W-1:0] value_q;

    // Alignment variant chosen by the word width.
    generate
        if (ALIGN_BITS > 0) begin : g_align
            always_comb begin
                base_al = {base[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                addr    = {addr_q[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            end
        end else begin : g_noalign
            always_comb begin
                base_al = base;
                addr    = addr_q;
            end
        end
    endgenerate

    // Address register: load aligned base, then advance one word per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= base_al;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(BYTES_PER_WORD);
        end
    end

    // Fill value register, captured once per operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (load) begin
            value_q <= value;
        end
    end

    always_comb begin
        wdata = value_q;
    end
endmodule

// File: rtl/fill_ctrl.sv
// Module fill_ctrl
// Three-state sequencer: idle, writing, finishing. Accepts a start only
// when idle and the opcode matches; start is ignored in the other states.
// Assumes cnt_zero and opc_match are decoded from the same instruction as start.
module fill_ctrl
    import fill_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic opc_match,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic mem_ready,
    output logic load,
    output logic step,
    output logic mem_we,
    output logic done
);
    fill_state_e state_q, state_d;

    // Handshake and load strobes derived from the current state.
    always_comb begin
        load   = (state_q == ST_IDLE) && start && opc_match;
        step   = (state_q == ST_WRITE) && mem_ready;
        mem_we = (state_q == ST_WRITE);
        done   = (state_q == ST_FINISH);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load) state_d = cnt_zero ? ST_FINISH : ST_WRITE;
            ST_WRITE:  if (step && cnt_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/fill_seq.sv
// Module fill_seq (top)
// Region fill sequencer: decodes the instruction, fetches base and value
// through the register-select outputs, then writes the value into
// consecutive words, one accepted write per ready cycle, and pulses done.
// Assumes val_data and base_data are valid in the cycle start is high.
module fill_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 6,
    parameter int SEL_W  = 3,
    parameter int OPC_W  = 4,
    parameter logic [OPC_W-1:0] OPCODE = 4'b1010,
    localparam int INSTR_W = OPC_W + 2*SEL_W + CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    output logic [SEL_W-1:0]   val_sel,
    output logic [SEL_W-1:0]   base_sel,
    input  logic [DATA_W-1:0]  val_data,
    input  logic [ADDR_W-1:0]  base_data,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    input  logic               mem_ready,
    output logic               done
);
    logic [CNT_W-1:0] count;
    logic             opc_match;
    logic             cnt_zero;
    logic             cnt_last;
    logic             load;
    logic             step;

    fill_decode #(
        .CNT_W(CNT_W), .SEL_W(SEL_W), .OPC_W(OPC_W), .OPCODE(OPCODE)
    ) u_dec (
        .instr     (instr),
        .val_sel   (val_sel),
        .base_sel  (base_sel),
        .count     (count),
        .opc_match (opc_match),
        .cnt_zero  (cnt_zero)
    );

    fill_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opc_match (opc_match),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .mem_ready (mem_ready),
        .load      (load),
        .step      (step),
        .mem_we    (mem_we),
        .done      (done)
    );

    fill_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (count),
        .dec      (step),
        .last     (cnt_last)
    );

    fill_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .base  (base_data),
        .value (val_data),
        .step  (step),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );
endmodule

// File: rtl/fill_seq_chk.sv
// Module fill_seq_chk
// Protocol checker for fill_seq, bound to every instance. Tracks its own
// busy window from an accepted start to done and checks the write handshake.
// Assumes mem_ready is a defined 0 or 1 every cycle.
module fill_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 6,
    parameter int SEL_W  = 3,
    parameter int OPC_W  = 4,
    parameter logic [OPC_W-1:0] OPCODE = 4'b1010,
    localparam int INSTR_W = OPC_W + 2*SEL_W + CNT_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               mem_we,
    input logic               mem_ready,
    input logic               done
);
    localparam int STRIDE = DATA_W / 8;

    logic chk_busy;
    logic opc_ok;
    logic accept;

    always_comb begin
        opc_ok = (instr[INSTR_W-1 -: OPC_W] == OPCODE);
        accept = start && opc_ok && !chk_busy;
    end

    // Independent busy window: set on accepted start, cleared on done.
    always_ff @(posedge clk) begin
        if (!rst_n)      chk_busy <= 1'b0;
        else if (accept) chk_busy <= 1'b1;
        else if (done)   chk_busy <= 1'b0;
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready) |=> (!mem_we || (mem_addr == $past(mem_addr) + ADDR_W'(STRIDE))));

    // R5
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_addr[0]);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    // R7
    zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && instr[CNT_W-1:0] == '0) |=> (done && !mem_we));

    // R2
    bad_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !opc_ok && !chk_busy) |=> (!mem_we && !done));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_busy |-> (!mem_we && !done));
endmodule

bind fill_seq fill_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .SEL_W(SEL_W), .OPC_W(OPC_W), .OPCODE(OPCODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .instr     (instr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .done      (done)
);

// File: tb/sim_fill_seq.sv
`timescale 1ns/1ps
module sim_fill_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] instr;
    logic [2:0]  val_sel, base_sel;
    logic [15:0] val_data, base_data;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_we;
    logic        mem_ready;
    logic        done;

    always #4 clk = ~clk;

    fill_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .val_sel(val_sel), .base_sel(base_sel),
        .val_data(val_data), .base_data(base_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_ready(mem_ready), .done(done)
    );

    logic [15:0] rf [8];
    assign val_data  = rf[val_sel];
    assign base_data = rf[base_sel];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] log_a [64];
    logic [15:0] log_d [64];
    int log_n = 0;
    int done_cnt = 0;
    int done_cyc = -1;
    int last_wr_cyc = -1;
    logic stall_en = 1'b0;
    logic hold_pend = 1'b0;
    logic [15:0] hold_a, hold_d;
    logic finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [15:0] base, input int i);
        return (base & 16'hFFFE) + 16'(2 * i);
    endfunction

    // Memory model: random ready, write log, hold and alignment checks.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b1;
            hold_pend = 1'b0;
        end else begin
            if (hold_pend)
                chk(mem_we && mem_addr == hold_a && mem_wdata == hold_d, "R6",
                    "held write", {mem_addr, mem_wdata}, {hold_a, hold_d});
            hold_pend = 1'b0;
            mem_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
            if (mem_we) begin
                chk(!mem_addr[0], "R5", "addr bit0", {31'd0, mem_addr[0]}, 32'd0);
                if (mem_ready) begin
                    if (log_n < 64) begin
                        log_a[log_n] = mem_addr;
                        log_d[log_n] = mem_wdata;
                    end
                    log_n++;
                    last_wr_cyc = cyc;
                end else begin
                    hold_pend = 1'b1;
                    hold_a = mem_addr;
                    hold_d = mem_wdata;
                end
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic run_op(input logic [2:0] vs, input logic [2:0] bs,
                          input logic [15:0] base, input logic [15:0] val,
                          input logic [5:0] n, input bit extra);
        logic [15:0] eb, ev;
        int st;
        bit seen;
        rf[bs] = base;
        rf[vs] = val;
        eb = rf[bs];
        ev = rf[vs];
        @(negedge clk);
        #1;
        instr = {4'b1010, vs, bs, n};
        log_n = 0;
        done_cnt = 0;
        done_cyc = -1;
        start = 1'b1;
        st = cyc;
        #1;
        chk(val_sel == vs && base_sel == bs, "R3", "selects",
            {26'd0, val_sel, base_sel}, {26'd0, vs, bs});
        @(negedge clk);
        #1;
        start = 1'b0;
        if (extra) begin
            // R9: restart attempts while the run is still writing
            instr = {4'b1010, ~vs, ~bs, 6'd1};
            start = 1'b1;
            repeat (3) @(negedge clk);
            #1;
            start = 1'b0;
        end
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            if (done_cnt != 0) begin
                seen = 1'b1;
                break;
            end
        end
        chk(seen, "R8", "done seen", {31'd0, seen}, 32'd1);
        repeat (6) @(negedge clk);
        #1;
        chk(done_cnt == 1, extra ? "R9" : "R8", "done pulses", done_cnt, 1);
        chk(log_n == int'(n), extra ? "R9" : "R4", "write count", log_n, {26'd0, n});
        for (int i = 0; i < int'(n) && i < log_n; i++) begin
            if (log_a[i] != exp_addr(eb, i) || log_d[i] != ev)
                chk(1'b0, "R4", "write entry", {log_a[i], log_d[i]}, {exp_addr(eb, i), ev});
        end
        checks++;
        if (n == 0)
            chk(done_cyc == st + 1, "R7", "zero-count done cycle", done_cyc, st + 1);
        else
            chk(done_cyc == last_wr_cyc + 1, "R8", "done after last write",
                done_cyc, last_wr_cyc + 1);
    endtask

    task automatic bad_op(input logic [3:0] opc);
        @(negedge clk);
        #1;
        log_n = 0;
        done_cnt = 0;
        instr = {opc, 3'd1, 3'd2, 6'd9};
        start = 1'b1;
        @(negedge clk);
        #1;
        start = 1'b0;
        repeat (8) @(negedge clk);
        #1;
        chk(log_n == 0, "R2", "writes on bad opcode", log_n, 0);
        chk(done_cnt == 0, "R2", "done on bad opcode", done_cnt, 0);
    endtask

    initial begin
        void'($urandom(32'h1F00D));
        for (int i = 0; i < 8; i++) rf[i] = 16'h0;
        rst_n = 1'b0;
        start = 1'b0;
        instr = 16'h0;
        repeat (3) @(negedge clk);
        chk(!mem_we && !done, "R1", "outputs in reset", {30'd0, mem_we, done}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!mem_we && !done, "R1", "outputs after reset", {30'd0, mem_we, done}, 32'd0);

        run_op(3'd1, 3'd0, 16'h3050, 16'h0007, 6'd5, 1'b0);   // R4 example run
        run_op(3'd2, 3'd3, 16'h4000, 16'hBEEF, 6'd0, 1'b0);   // R7 zero count
        run_op(3'd4, 3'd5, 16'h1235, 16'h5A5A, 6'd3, 1'b0);   // R5 odd base
        run_op(3'd6, 3'd7, 16'hFFFC, 16'h1234, 6'd4, 1'b0);   // R10 wrap
        run_op(3'd0, 3'd1, 16'h8000, 16'hFFFF, 6'd63, 1'b0);  // R4 max count
        run_op(3'd3, 3'd3, 16'h2000, 16'h2000, 6'd2, 1'b0);   // R3 same selector
        run_op(3'd1, 3'd2, 16'h0100, 16'h00AA, 6'd6, 1'b1);   // R9 restart ignored
        bad_op(4'b0000);                                      // R2
        bad_op(4'b1011);                                      // R2

        stall_en = 1'b1;
        run_op(3'd5, 3'd6, 16'h7FF0, 16'hC3C3, 6'd12, 1'b1);  // R6 stalled + R9
        for (int k = 0; k < 25; k++) begin
            logic [5:0] n;
            n = 6'($urandom_range(63));
            run_op(3'($urandom_range(7)), 3'($urandom_range(7)),
                   16'($urandom), 16'($urandom), n,
                   (n >= 6'd4) && ($urandom_range(1) == 1));
        end
        bad_op(4'b0101);                                      // R2 under stalls
        run_op(3'd2, 3'd4, 16'hFFFE, 16'h0F0F, 6'd3, 1'b0);   // R10 wrap stalled

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule